// File: doc/BRIEF.md
# CAN Base-Frame Transmitter with Bitwise Arbitration

This block sends one base-format CAN frame onto a wired-AND bus line, where logic 0 is dominant and logic 1 is recessive, and resolves collisions without destroying the winning frame. The host hands over a request carrying an 11-bit message identifier, a remote-request flag, a 4-bit data length code and a 64-bit data word. The block captures the request and waits for the next bit strobe. It then serializes start-of-frame, identifier, RTR, the two reserved bits, the length code, the data bytes and a 15-bit CRC. After the CRC come the CRC delimiter, the ACK slot and the ACK delimiter.

On each bit strobe the block reads back the bus line for the bit it is driving. During the identifier and the RTR bit, a recessive bit that reads back dominant means a lower-valued identifier, which has higher priority, is on the bus. The block then releases the line and stops. The ACK slot is always driven recessive so that a receiver can pull it dominant. One-cycle status pulses report whether arbitration was won or lost and whether the ACK slot was found dominant or recessive. Bit stuffing, error frames, error counters and extended identifiers are not part of this block.

The request port is a valid/ready stream. A transfer happens on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the block is idle, so the host holds its request, with stable fields, for as long as the block is busy. The status pins and the bit-strobe input are plain signals with no handshake.

Top module: `can_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `bus_tx` is 1 (recessive), `req_ready` is 1 and all four status pulses are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is 0 from that edge until the frame ends. Changes on the request inputs after the transfer do not affect the frame on the bus.
- R3: `bus_tx` stays recessive until the first bit strobe after the transfer. At that strobe, `bus_tx` becomes the dominant start-of-frame bit. Frame bits change only on a strobe, one bit per strobe.
- R4: After start-of-frame, the block sends the 11 identifier bits MSB first, then the RTR flag (1 means remote request), then two dominant reserved bits, then the 4-bit length code exactly as given, MSB first.
- R5: The data field follows. The byte count is 0 when RTR is 1. Otherwise it is the length code, with any code above 8 treated as 8. Bytes are taken from `req_data` starting at bits [63:56], and each byte is sent MSB first.
- R6: The CRC covers start-of-frame through the last data bit. It uses polynomial 0x4599 (x^15+x^14+x^10+x^8+x^7+x^4+x^3+1) and starts from zero. Each bit XOR the register MSB decides whether the shifted register is XORed with the polynomial. The 15-bit result is sent MSB first, followed by a recessive delimiter.
- R7: When the block sends a recessive identifier or RTR bit and reads dominant at that strobe, `arb_lost` pulses and the block returns to idle at that strobe. From then on `bus_tx` stays recessive.
- R8: If arbitration is not lost through the RTR bit, `arb_won` pulses at the RTR strobe. At most one status pulse is high in any cycle.
- R9: The ACK slot is sent recessive. If it reads dominant, `ack_ok` pulses, a recessive ACK delimiter follows, and the block goes idle at the delimiter strobe.
- R10: If the ACK slot reads recessive, `ack_missing` pulses and the block goes idle at that same strobe, without sending the delimiter bit.
- R11: A dominant read-back outside the identifier, the RTR bit and the ACK slot (for example, on the CRC delimiter) is ignored. The frame continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_id | input | 11 | Message identifier |
| req_rtr | input | 1 | Remote-request flag |
| req_dlc | input | 4 | Data length code |
| req_data | input | 64 | Data bytes, first byte in [63:56] |
| bit_tick | input | 1 | One-cycle bit strobe from the bit timing logic |
| bus_rx | input | 1 | Level read back from the bus line |
| bus_tx | output | 1 | Level driven to the bus line (1 = released) |
| arb_won | output | 1 | Pulse: arbitration field passed without loss |
| arb_lost | output | 1 | Pulse: arbitration lost, bus released |
| ack_ok | output | 1 | Pulse: ACK slot read dominant |
| ack_missing | output | 1 | Pulse: ACK slot read recessive |

## Verification
The bench builds the block with its default parameters: an 11-bit identifier, a 4-bit length code, eight data bytes and a 15-bit CRC. With these values the full 101-bit frame can be exercised, including the clamp of length codes 9 to 15 down to eight bytes. A modeled second node drives its own identifier onto the wired-AND line. This covers loss at an early identifier bit, loss at the RTR bit against a data frame with the same identifier, and a win against a higher identifier. A modeled receiver that pulls or leaves the ACK slot exercises both acknowledgement outcomes.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND
  } tx_state_t;

  typedef enum logic [2:0] {
    SEG_SOF,
    SEG_ID,
    SEG_RTR,
    SEG_CTRL,
    SEG_DATA,
    SEG_CRC,
    SEG_ACK_SLOT,
    SEG_TAIL
  } seg_t;

endpackage

// File: rtl/can_crc15.sv
module can_crc15 #(
  parameter int CRC_W = 15,
  parameter logic [CRC_W-1:0] POLY = 15'h4599
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] nxt;

  always_comb begin
    nxt = {crc[CRC_W-2:0], 1'b0};
    if (din ^ crc[CRC_W-1]) nxt = nxt ^ POLY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
  end

  // R6
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/can_frame_bits.sv
module can_frame_bits import can_tx_pkg::*; #(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int CRC_W     = 15,
  parameter int POS_W     = 7
) (
  input  logic [POS_W-1:0]       pos,
  input  logic [ID_W-1:0]        id,
  input  logic                   rtr,
  input  logic [DLC_W-1:0]       dlc,
  input  logic [MAX_BYTES*8-1:0] data,
  input  logic [CRC_W-1:0]       crc,
  output logic                   frame_bit,
  output seg_t                   seg,
  output logic                   last
);

  localparam int DATA_W = MAX_BYTES * 8;
  localparam int HDR_W  = 1 + ID_W + 1 + 2 + DLC_W + DATA_W;
  localparam logic [POS_W-1:0] ID_LAST    = POS_W'(ID_W);
  localparam logic [POS_W-1:0] RTR_POS    = POS_W'(ID_W + 1);
  localparam logic [POS_W-1:0] DATA_START = POS_W'(1 + ID_W + 1 + 2 + DLC_W);

  logic [HDR_W-1:0] hdr, hdr_sh;
  logic [CRC_W-1:0] crc_sh;
  logic [POS_W-1:0] nbytes, crc_start, delim_pos, slot_pos, tail_pos;

  always_comb begin
    if (rtr)                              nbytes = '0;
    else if (dlc > DLC_W'(MAX_BYTES))     nbytes = POS_W'(MAX_BYTES);
    else                                  nbytes = POS_W'(dlc);
    crc_start = DATA_START + (nbytes << 3);
    delim_pos = crc_start + POS_W'(CRC_W);
    slot_pos  = delim_pos + 1'b1;
    tail_pos  = slot_pos + 1'b1;
  end

  assign hdr    = {1'b0, id, rtr, 2'b00, dlc, data};
  assign hdr_sh = hdr << pos;
  assign crc_sh = crc << (pos - crc_start);
  assign last   = (pos == tail_pos);

  always_comb begin
    frame_bit = 1'b1;
    seg       = SEG_TAIL;
    if (pos < crc_start) begin
      frame_bit = hdr_sh[HDR_W-1];
      if (pos == '0)             seg = SEG_SOF;
      else if (pos <= ID_LAST)   seg = SEG_ID;
      else if (pos == RTR_POS)   seg = SEG_RTR;
      else if (pos < DATA_START) seg = SEG_CTRL;
      else                       seg = SEG_DATA;
    end else if (pos < delim_pos) begin
      frame_bit = crc_sh[CRC_W-1];
      seg       = SEG_CRC;
    end else if (pos == slot_pos) begin
      seg       = SEG_ACK_SLOT;
    end
  end

endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl import can_tx_pkg::*; #(
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             bit_tick,
  input  logic             bus_rx,
  input  logic             frame_bit,
  input  seg_t             seg,
  input  logic             last,
  output logic             req_ready,
  output logic             accept,
  output logic             sending,
  output logic [POS_W-1:0] pos,
  output logic             crc_en,
  output logic             won,
  output logic             lost,
  output logic             ack_ok,
  output logic             ack_missing
);

  tx_state_t state_q;
  logic      strobe, in_arb, lose_now;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    sending   = (state_q == ST_SEND);
    strobe    = bit_tick && sending;
    in_arb    = (seg == SEG_ID) || (seg == SEG_RTR);
    lose_now  = strobe && in_arb && frame_bit && !bus_rx;
    crc_en    = strobe && !lose_now &&
                (seg inside {SEG_SOF, SEG_ID, SEG_RTR, SEG_CTRL, SEG_DATA});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pos         <= '0;
      won         <= 1'b0;
      lost        <= 1'b0;
      ack_ok      <= 1'b0;
      ack_missing <= 1'b0;
    end else begin
      won         <= 1'b0;
      lost        <= 1'b0;
      ack_ok      <= 1'b0;
      ack_missing <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_WAIT;
        ST_WAIT: if (bit_tick) begin
          state_q <= ST_SEND;
          pos     <= '0;
        end
        ST_SEND: if (bit_tick) begin
          if (lose_now) begin
            lost    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (seg == SEG_ACK_SLOT) begin
            if (!bus_rx) begin
              ack_ok <= 1'b1;
              pos    <= pos + 1'b1;
            end else begin
              ack_missing <= 1'b1;
              state_q     <= ST_IDLE;
            end
          end else if (last) begin
            state_q <= ST_IDLE;
          end else begin
            if (seg == SEG_RTR) won <= 1'b1;
            pos <= pos + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({won, lost, ack_ok, ack_missing}));

  // R3
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && !bit_tick) |=> $stable(pos));

  // R10
  missing_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_missing |-> req_ready);

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx import can_tx_pkg::*; #(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int CRC_W     = 15,
  parameter logic [CRC_W-1:0] CRC_POLY = 15'h4599
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_rtr,
  input  logic [DLC_W-1:0]       req_dlc,
  input  logic [MAX_BYTES*8-1:0] req_data,
  input  logic                   bit_tick,
  input  logic                   bus_rx,
  output logic                   bus_tx,
  output logic                   arb_won,
  output logic                   arb_lost,
  output logic                   ack_ok,
  output logic                   ack_missing
);

  localparam int HDR_W     = 1 + ID_W + 1 + 2 + DLC_W + MAX_BYTES * 8;
  localparam int FRAME_MAX = HDR_W + CRC_W + 3;
  localparam int POS_W     = $clog2(FRAME_MAX + 1);

  logic [ID_W-1:0]        id_q;
  logic                   rtr_q;
  logic [DLC_W-1:0]       dlc_q;
  logic [MAX_BYTES*8-1:0] data_q;
  logic [CRC_W-1:0]       crc;
  logic [POS_W-1:0]       pos;
  logic                   accept, sending, crc_en, frame_bit, last;
  seg_t                   seg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q   <= '0;
      rtr_q  <= 1'b0;
      dlc_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      id_q   <= req_id;
      rtr_q  <= req_rtr;
      dlc_q  <= req_dlc;
      data_q <= req_data;
    end
  end

  can_frame_bits #(
    .ID_W(ID_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES),
    .CRC_W(CRC_W), .POS_W(POS_W)
  ) i_bits (
    .pos(pos), .id(id_q), .rtr(rtr_q), .dlc(dlc_q), .data(data_q),
    .crc(crc), .frame_bit(frame_bit), .seg(seg), .last(last)
  );

  can_crc15 #(.CRC_W(CRC_W), .POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst_n(rst_n), .clr(accept), .en(crc_en),
    .din(frame_bit), .crc(crc)
  );

  can_tx_ctrl #(.POS_W(POS_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .bit_tick(bit_tick),
    .bus_rx(bus_rx), .frame_bit(frame_bit), .seg(seg), .last(last),
    .req_ready(req_ready), .accept(accept), .sending(sending), .pos(pos),
    .crc_en(crc_en), .won(arb_won), .lost(arb_lost), .ack_ok(ack_ok),
    .ack_missing(ack_missing)
  );

  assign bus_tx = sending ? frame_bit : 1'b1;

  // R3
  sof_dominant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && pos == '0) |-> !bus_tx);

  // R9
  ack_slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && seg == SEG_ACK_SLOT) |-> bus_tx);

  // R7
  lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (bus_tx && req_ready));

endmodule

// File: tb/test_can_frame_tx.sv
module test_can_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_id = '0;
  logic        req_rtr = 1'b0;
  logic [3:0]  req_dlc = '0;
  logic [63:0] req_data = '0;
  logic        bit_tick = 1'b0;
  logic        bus_rx;
  logic        bus_tx;
  logic        arb_won, arb_lost, ack_ok, ack_missing;
  logic        comp_drv = 1'b1, ack_drv = 1'b1, noise_drv = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic e_bits [0:127];
  logic c_bits [0:127];

  always #2 clk = ~clk;

  assign bus_rx = bus_tx & comp_drv & ack_drv & noise_drv;

  can_frame_tx i_can_frame_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_dlc(req_dlc), .req_data(req_data),
    .bit_tick(bit_tick), .bus_rx(bus_rx), .bus_tx(bus_tx),
    .arb_won(arb_won), .arb_lost(arb_lost), .ack_ok(ack_ok),
    .ack_missing(ack_missing)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  // {id, rtr, dlc, data, comp_en, comp_id, ack, outcome}; outcome 0 acked, 1 no ack, 2 lost
  localparam int VW = 95;
  localparam int NV = 7;
  localparam logic [VW-1:0] VEC [NV] = '{
    {11'h123, 1'b0, 4'd2,  64'hABCD_0000_0000_0000, 1'b0, 11'h000, 1'b1, 2'd0},
    {11'h7FF, 1'b0, 4'd0,  64'h0,                   1'b0, 11'h000, 1'b0, 2'd1},
    {11'h555, 1'b1, 4'd4,  64'hFFFF_FFFF_0000_0000, 1'b0, 11'h000, 1'b1, 2'd0},
    {11'h0F0, 1'b0, 4'd12, 64'h0123_4567_89AB_CDEF, 1'b0, 11'h000, 1'b1, 2'd0},
    {11'h300, 1'b0, 4'd1,  64'h5A00_0000_0000_0000, 1'b1, 11'h2FF, 1'b1, 2'd2},
    {11'h100, 1'b1, 4'd0,  64'h0,                   1'b1, 11'h100, 1'b1, 2'd2},
    {11'h200, 1'b0, 4'd8,  64'hFEDC_BA98_7654_3210, 1'b1, 11'h3FF, 1'b1, 2'd0}
  };

  task automatic run_frame(input logic [10:0] id, input logic rtr,
                           input logic [3:0] dlc, input logic [63:0] data,
                           input logic comp_en, input logic [10:0] comp_id,
                           input logic ack, input logic noise,
                           input logic [1:0] exp_out);
    int n, nb, slot, crc_start, lk, outcome;
    logic [14:0] c;
    logic fb;
    bit stop;
    string tag;
    n = 0;
    e_bits[n++] = 1'b0;
    for (int b = 10; b >= 0; b--) e_bits[n++] = id[b];
    e_bits[n++] = rtr;
    e_bits[n++] = 1'b0;
    e_bits[n++] = 1'b0;
    for (int b = 3; b >= 0; b--) e_bits[n++] = dlc[b];
    nb = rtr ? 0 : ((dlc > 8) ? 8 : int'(dlc));
    for (int j = 0; j < nb; j++)
      for (int b = 7; b >= 0; b--) e_bits[n++] = data[56 - 8*j + b];
    crc_start = n;
    c = '0;
    for (int i = 0; i < crc_start; i++) begin
      fb = e_bits[i] ^ c[14];
      c  = {c[13:0], 1'b0};
      if (fb) c = c ^ 15'h4599;
    end
    for (int b = 14; b >= 0; b--) e_bits[n++] = c[b];
    e_bits[n++] = 1'b1;
    slot = n;
    e_bits[n++] = 1'b1;
    e_bits[n++] = 1'b1;
    lk = 255;
    for (int k = 0; k < 128; k++) begin
      c_bits[k] = 1'b1;
      if (comp_en && k == 0) c_bits[k] = 1'b0;
      if (comp_en && k >= 1 && k <= 11) c_bits[k] = comp_id[11 - k];
      if (comp_en && k == 12) c_bits[k] = 1'b0;
      if (lk == 255 && k >= 1 && k <= 12 && e_bits[k] && !c_bits[k]) lk = k;
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_id = id; req_rtr = rtr; req_dlc = dlc; req_data = data;
    @(negedge clk);
    req_valid = 1'b0; req_id = ~id; req_rtr = ~rtr; req_dlc = ~dlc; req_data = ~data;
    chk(req_ready == 1'b0, "R2 ready low after transfer", 64'(req_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk(bus_tx == 1'b1, "R3 recessive before first strobe", 64'(bus_tx), 64'd1);
    strobe();
    outcome = 3;
    stop = 1'b0;
    for (int k = 0; k < n && !stop; k++) begin
      repeat (2) @(negedge clk);
      comp_drv  = c_bits[k];
      ack_drv   = (ack && k == slot) ? 1'b0 : 1'b1;
      noise_drv = (noise && k == slot - 1) ? 1'b0 : 1'b1;
      if (k == 0) tag = "R3 start bit";
      else if (k < 19) tag = "R4 header bit";
      else if (k < crc_start) tag = "R5 data bit";
      else if (k < slot) tag = "R6 crc bit";
      else tag = "R9 ack bit";
      chk(bus_tx == e_bits[k], tag, 64'(bus_tx), 64'(e_bits[k]));
      strobe();
      chk({arb_won, arb_lost, ack_ok, ack_missing} ==
          {(k == 12 && lk == 255), (k == lk), (k == slot && ack), (k == slot && !ack)},
          "R8 status pulses", 64'({arb_won, arb_lost, ack_ok, ack_missing}),
          64'({(k == 12 && lk == 255), (k == lk), (k == slot && ack), (k == slot && !ack)}));
      if (arb_lost) outcome = 2;
      if (ack_ok) outcome = 0;
      if (ack_missing) outcome = 1;
      if (k == lk || (k == slot && !ack)) stop = 1'b1;
    end
    if (lk != 255) begin
      for (int k = lk + 1; k < lk + 4; k++) begin
        comp_drv = c_bits[k];
        strobe();
        chk(bus_tx == 1'b1, "R7 bus released after loss", 64'(bus_tx), 64'd1);
      end
    end
    comp_drv = 1'b1; ack_drv = 1'b1; noise_drv = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_tx == 1'b1, "R10 idle after frame",
        64'({req_ready, bus_tx}), 64'h3);
    chk(outcome == int'(exp_out), "R7 R9 R10 outcome", 64'(outcome), 64'(exp_out));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_tx == 1'b1 && req_ready == 1'b1, "R1 reset outputs",
        64'({bus_tx, req_ready}), 64'h3);
    chk({arb_won, arb_lost, ack_ok, ack_missing} == 4'b0, "R1 reset pulses",
        64'({arb_won, arb_lost, ack_ok, ack_missing}), 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      run_frame(v[94:84], v[83], v[82:79], v[78:15], v[14], v[13:3], v[2], 1'b0, v[1:0]);
    end

    // R11 dominant read on the CRC delimiter is ignored
    run_frame(11'h42A, 1'b0, 4'd3, 64'h1122_3300_0000_0000, 1'b0, 11'h0, 1'b1, 1'b1, 2'd0);

    // R1 reset in the middle of a frame returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_id = 11'h001; req_rtr = 1'b0; req_dlc = 4'd1;
    @(negedge clk) req_valid = 1'b0;
    repeat (5) strobe();
    chk(bus_tx == 1'b0, "R4 leading identifier zero bit", 64'(bus_tx), 64'd0);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(bus_tx == 1'b1 && req_ready == 1'b1, "R1 mid-frame reset",
        64'({bus_tx, req_ready}), 64'h3);
    rst_n = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule